// File: doc/BRIEF.md
# Integer Decode and Execute Unit

This block takes one 32-bit instruction word per clock and executes it against a register file of 32 entries, each 32 bits wide. The register file has two read ports and one write port. Decode, operand selection and the arithmetic or logic operation are all combinational. The write-back lands in the register file on the next rising clock edge. As a result, an instruction presented in one cycle sees the results of every instruction accepted in earlier cycles.

Two instruction formats are decoded:
- **Register form:** three register operands, plus a shift amount field.
- **Immediate form:** two register operands and a 16-bit constant.

Arithmetic immediates and memory offsets are sign-extended, while logical immediates are zero-extended. For loads and stores, the unit computes the effective byte address and raises a read or write strobe. Load data comes back on an input in the same cycle and is written to the destination register. An instruction the unit does not recognise raises a flag and changes nothing.

Top module: `exu_core`

## Requirements
- R1: Bits [31:26] form the opcode. For opcode 0, bits [25:21], [20:16] and [15:11] name source A, source B and the destination, and bits [5:0] select the operation. Code 0x20 adds, 0x22 subtracts (A minus B), and both wrap modulo 2^32 with no trap. The result appears on `result` and is written to the destination at the next clock edge.
- R2: Register-form codes 0x24, 0x25, 0x26 and 0x27 produce bitwise AND, OR, XOR and NOR of A and B. NOR with register 0 yields the bitwise complement.
- R3: Register-form codes 0x00, 0x02 and 0x03 shift source B by the amount in bits [10:6]. These are left-logical, right-logical (zero fill) and right-arithmetic (sign fill).
- R4: Opcode 0x08 adds the sign-extended 16-bit constant in bits [15:0] to the register in bits [25:21]. It writes the sum to the register in bits [20:16].
- R5: Opcodes 0x0C, 0x0D and 0x0E apply AND, OR and XOR between the register in bits [25:21] and the zero-extended constant. The result goes to the register in bits [20:16].
- R6: Opcode 0x23 drives `mem_addr` with base register [25:21] plus the sign-extended constant and raises `mem_rd`. It writes `ld_data` to register [20:16].
- R7: Opcode 0x2B drives `mem_addr` the same way and raises `mem_wr`. It presents register [20:16] on `mem_wdata` and writes no register.
- R8: Register 0 always reads as zero. An instruction whose destination is register 0 leaves `rf_we` low and changes no state.
- R9: Any other opcode, or a register-form code outside those above, raises `illegal`. It keeps `rf_we`, `mem_rd` and `mem_wr` low.
- R10: With `instr_vld` low, `rf_we`, `mem_rd`, `mem_wr` and `illegal` stay low and no register changes.
- R11: A synchronous active-high reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_vld | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| ld_data | input | 32 | Data returned for a load in the same cycle |
| result | output | 32 | Value to be written back |
| rf_we | output | 1 | Register write occurs at the next edge |
| rf_waddr | output | 5 | Destination register index |
| mem_addr | output | 32 | Effective byte address of a load or store |
| mem_rd | output | 1 | Load strobe |
| mem_wr | output | 1 | Store strobe |
| mem_wdata | output | 32 | Store data |
| illegal | output | 1 | Unrecognised instruction |

## Verification
The bench first builds known values from constants chosen to separate the two immediate extensions: 0x8000 versus 0x7FFF, and -1 versus 0xFFFF. It then shifts a value with its top bit set, so that zero fill and sign fill give different answers, and adds 0x80000000 to itself to expose wrap-around. Reads through register 0, writes aimed at register 0, unknown codes and invalid cycles are each followed by a read of the register they could have disturbed. A long stream of random legal and illegal instructions with random register indices then exercises read-after-write chains and aliasing of source and destination. Every output is compared against a behavioural model on every cycle.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int XLEN  = 32;
    localparam int NREGS = 32;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_ANDI  = 6'h0C;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_XORI  = 6'h0E;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_SLL = 6'h00;
    localparam logic [5:0] FN_SRL = 6'h02;
    localparam logic [5:0] FN_SRA = 6'h03;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_NOR = 6'h27;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
        ALU_NOR, ALU_SLL, ALU_SRL, ALU_SRA
    } alu_op_e;

    typedef enum logic [1:0] {
        BSEL_REG, BSEL_SEXT, BSEL_ZEXT
    } bsel_e;

    typedef struct packed {
        alu_op_e     op;
        bsel_e       bsel;
        logic        we;
        logic        ld;
        logic        st;
        logic        illegal;
        logic [4:0]  dest;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  shamt;
        logic [15:0] imm;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] zext16(input logic [15:0] v);
        return {{(XLEN-16){1'b0}}, v};
    endfunction

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic        vld,
    input  logic [31:0] instr,
    output ctrl_t       ctrl
);
    logic [5:0] opc;
    logic [5:0] fn;
    ctrl_t      raw;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];

    always_comb begin
        raw         = '0;
        raw.op      = ALU_ADD;
        raw.bsel    = BSEL_REG;
        raw.rs      = instr[25:21];
        raw.rt      = instr[20:16];
        raw.shamt   = instr[10:6];
        raw.imm     = instr[15:0];
        if (opc == OPC_RTYPE) begin
            raw.we   = 1'b1;
            raw.dest = instr[15:11];
            case (fn)
                FN_ADD:  raw.op = ALU_ADD;
                FN_SUB:  raw.op = ALU_SUB;
                FN_AND:  raw.op = ALU_AND;
                FN_OR:   raw.op = ALU_OR;
                FN_XOR:  raw.op = ALU_XOR;
                FN_NOR:  raw.op = ALU_NOR;
                FN_SLL:  raw.op = ALU_SLL;
                FN_SRL:  raw.op = ALU_SRL;
                FN_SRA:  raw.op = ALU_SRA;
                default: raw.illegal = 1'b1;
            endcase
        end else begin
            raw.dest = instr[20:16];
            case (opc)
                OPC_ADDI:  begin raw.we = 1'b1; raw.bsel = BSEL_SEXT; raw.op = ALU_ADD; end
                OPC_ANDI:  begin raw.we = 1'b1; raw.bsel = BSEL_ZEXT; raw.op = ALU_AND; end
                OPC_ORI:   begin raw.we = 1'b1; raw.bsel = BSEL_ZEXT; raw.op = ALU_OR;  end
                OPC_XORI:  begin raw.we = 1'b1; raw.bsel = BSEL_ZEXT; raw.op = ALU_XOR; end
                OPC_LOAD:  begin raw.we = 1'b1; raw.ld = 1'b1; raw.bsel = BSEL_SEXT; end
                OPC_STORE: begin raw.st = 1'b1; raw.bsel = BSEL_SEXT; end
                default:   raw.illegal = 1'b1;
            endcase
        end
    end

    always_comb begin
        ctrl = raw;
        if (!vld || raw.illegal) begin
            ctrl.we = 1'b0;
            ctrl.ld = 1'b0;
            ctrl.st = 1'b0;
        end
        if (raw.dest == 5'd0) begin
            ctrl.we = 1'b0;
        end
        ctrl.illegal = raw.illegal & vld;
    end

endmodule

// File: rtl/exu_regfile.sv
module exu_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NREG)-1:0] ra,
    input  logic [$clog2(NREG)-1:0] rb,
    output logic [DW-1:0]           rdata_a,
    output logic [DW-1:0]           rdata_b,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] wa,
    input  logic [DW-1:0]           wd
);
    localparam int AW = $clog2(NREG);

    logic [DW-1:0] mem [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        if (i == 0) begin : g_zero
            assign mem[i] = '0;
        end else begin : g_reg
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (we && wa == AW'(i)) begin
                    q <= wd;
                end
            end
            assign mem[i] = q;
        end
    end

    assign rdata_a = mem[ra];
    assign rdata_b = mem[rb];

    // a non-zero write is visible on a read port one cycle later (R1)
    p_wr_visible_r1: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> (ra != $past(wa) || rdata_a == $past(wd)));

    // register zero stays zero whatever is written (R8)
    p_zero_reads_r8: assert property (@(posedge clk) disable iff (rst)
        (rb == '0) |-> (rdata_b == '0));

endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e                 op,
    input  logic [DW-1:0]           a,
    input  logic [DW-1:0]           b,
    input  logic [$clog2(DW)-1:0]   sh,
    output logic [DW-1:0]           y
);
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_NOR: y = ~(a | b);
            ALU_SLL: y = b << sh;
            ALU_SRL: y = b >> sh;
            ALU_SRA: y = DW'($signed(b) >>> sh);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/exu_core.sv
module exu_core
    import exu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        instr_vld,
    input  logic [31:0] instr,
    input  logic [31:0] ld_data,
    output logic [31:0] result,
    output logic        rf_we,
    output logic [4:0]  rf_waddr,
    output logic [31:0] mem_addr,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [31:0] mem_wdata,
    output logic        illegal
);
    localparam int SHW = $clog2(XLEN);

    ctrl_t            ctrl;
    logic [XLEN-1:0]  rs_val;
    logic [XLEN-1:0]  rt_val;
    logic [XLEN-1:0]  opnd_b;
    logic [XLEN-1:0]  alu_y;

    exu_decode u_dec (
        .vld   (instr_vld),
        .instr (instr),
        .ctrl  (ctrl)
    );

    exu_regfile #(.DW(XLEN), .NREG(NREGS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra      (ctrl.rs),
        .rb      (ctrl.rt),
        .rdata_a (rs_val),
        .rdata_b (rt_val),
        .we      (rf_we),
        .wa      (rf_waddr),
        .wd      (result)
    );

    always_comb begin
        case (ctrl.bsel)
            BSEL_SEXT: opnd_b = sext16(ctrl.imm);
            BSEL_ZEXT: opnd_b = zext16(ctrl.imm);
            default:   opnd_b = rt_val;
        endcase
    end

    exu_alu #(.DW(XLEN)) u_alu (
        .op (ctrl.op),
        .a  (rs_val),
        .b  (opnd_b),
        .sh (SHW'(ctrl.shamt)),
        .y  (alu_y)
    );

    assign result    = ctrl.ld ? ld_data : alu_y;
    assign rf_we     = ctrl.we;
    assign rf_waddr  = ctrl.dest;
    assign mem_addr  = alu_y;
    assign mem_rd    = ctrl.ld;
    assign mem_wr    = ctrl.st;
    assign mem_wdata = rt_val;
    assign illegal   = ctrl.illegal;

    p_ld_st_excl_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));

    p_store_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> !rf_we);

    p_no_zero_write_r8: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_waddr != 5'd0));

    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!rf_we && !mem_rd && !mem_wr));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !instr_vld |-> (!rf_we && !mem_rd && !mem_wr && !illegal));

endmodule

// File: tb/tb_exu_core.sv
module tb_exu_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_vld = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] result;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [31:0] mem_wdata;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    logic [31:0] mreg [32];

    always #2 clk = ~clk;

    exu_core dut (
        .clk(clk), .rst(rst), .instr_vld(instr_vld), .instr(instr),
        .ld_data(ld_data), .result(result), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .illegal(illegal)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rty(input int f, input int d, input int s,
                                        input int t, input int sh);
        return {6'h00, 5'(s), 5'(t), 5'(d), 5'(sh), 6'(f)};
    endfunction

    function automatic logic [31:0] ity(input int o, input int t, input int s,
                                        input logic [15:0] imm);
        return {6'(o), 5'(s), 5'(t), imm};
    endfunction

    task automatic run(input logic v, input logic [31:0] ins,
                       input logic [31:0] ld, input string tag);
        logic [5:0]  op;
        logic [5:0]  fn;
        logic [4:0]  rs, rt, rd, sh, dest;
        logic [31:0] a, b, se, ze, res, addr;
        logic        we, mrd, mwr, ill;
        op = ins[31:26]; fn = ins[5:0];
        rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; sh = ins[10:6];
        a = mreg[rs]; b = mreg[rt];
        se = {{16{ins[15]}}, ins[15:0]};
        ze = {16'h0, ins[15:0]};
        res = '0; addr = '0; we = 0; mrd = 0; mwr = 0; ill = 0; dest = rt;
        if (op == 6'h00) begin
            dest = rd; we = 1;
            case (fn)
                6'h20: res = a + b;
                6'h22: res = a - b;
                6'h24: res = a & b;
                6'h25: res = a | b;
                6'h26: res = a ^ b;
                6'h27: res = ~(a | b);
                6'h00: res = b << sh;
                6'h02: res = b >> sh;
                6'h03: res = 32'($signed(b) >>> sh);
                default: begin ill = 1; we = 0; end
            endcase
        end else begin
            case (op)
                6'h08: begin we = 1; res = a + se; end
                6'h0C: begin we = 1; res = a & ze; end
                6'h0D: begin we = 1; res = a | ze; end
                6'h0E: begin we = 1; res = a ^ ze; end
                6'h23: begin we = 1; mrd = 1; addr = a + se; res = ld; end
                6'h2B: begin mwr = 1; addr = a + se; end
                default: ill = 1;
            endcase
        end
        if (!v) begin we = 0; mrd = 0; mwr = 0; ill = 0; end
        if (dest == 5'd0) we = 0;

        @(negedge clk);
        instr_vld = v; instr = ins; ld_data = ld;
        #1;
        chk(illegal == ill, tag, "illegal", 32'(illegal), 32'(ill));
        chk(rf_we == we, tag, "rf_we", 32'(rf_we), 32'(we));
        chk(mem_rd == mrd && mem_wr == mwr, tag, "mem_rd/mem_wr",
            {30'h0, mem_rd, mem_wr}, {30'h0, mrd, mwr});
        if (we) begin
            chk(rf_waddr == dest, tag, "rf_waddr", 32'(rf_waddr), 32'(dest));
            chk(result == res, tag, "result", result, res);
        end
        if (mrd || mwr) chk(mem_addr == addr, tag, "mem_addr", mem_addr, addr);
        if (mwr) chk(mem_wdata == b, tag, "mem_wdata", mem_wdata, b);
        if (we) mreg[dest] = res;
    endtask

    // read register k through an OR with register 0 into destination 31
    task automatic peek(input int k, input logic [31:0] exp, input string tag);
        @(negedge clk);
        instr_vld = 1; instr = rty('h25, 31, k, 0, 0); ld_data = '0;
        #1;
        chk(result == exp, tag, "register read", result, exp);
        mreg[31] = result;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: every register cleared by reset
        for (int k = 1; k < 31; k++) peek(k, 32'h0, "R11");

        run(1, ity('h08, 1, 0, 16'h7FFF), 0, "R4");
        run(1, ity('h08, 2, 0, 16'hFFFF), 0, "R4");   // -1 -> all ones
        run(1, ity('h0D, 3, 0, 16'h8000), 0, "R5");   // zero-extended
        run(1, rty('h00, 4, 0, 3, 16), 0, "R3");      // 0x80000000
        run(1, rty('h03, 5, 0, 4, 4), 0, "R3");       // sign fill
        run(1, rty('h02, 6, 0, 4, 4), 0, "R3");       // zero fill
        run(1, rty('h00, 14, 0, 1, 0), 0, "R3");      // shift by zero
        run(1, rty('h20, 7, 4, 4, 0), 0, "R1");       // wraps to 0
        run(1, rty('h22, 8, 0, 1, 0), 0, "R1");
        run(1, rty('h20, 15, 2, 1, 0), 0, "R1");
        run(1, rty('h24, 16, 2, 3, 0), 0, "R2");
        run(1, rty('h25, 17, 5, 1, 0), 0, "R2");
        run(1, rty('h26, 18, 2, 1, 0), 0, "R2");
        run(1, rty('h27, 9, 1, 0, 0), 0, "R2");       // complement
        run(1, ity('h0C, 10, 2, 16'hFFFF), 0, "R5");
        run(1, ity('h0E, 11, 2, 16'h00FF), 0, "R5");
        run(1, ity('h23, 12, 3, 16'hFFFC), 32'hCAFE_F00D, "R6");
        peek(12, 32'hCAFE_F00D, "R6");
        run(1, ity('h2B, 12, 1, 16'h0008), 0, "R7");
        run(1, ity('h2B, 0, 0, 16'h8000), 0, "R7");
        peek(12, 32'hCAFE_F00D, "R7");
        run(1, ity('h08, 0, 1, 16'h0005), 0, "R8");
        run(1, rty('h20, 0, 2, 2, 0), 0, "R8");
        run(1, ity('h23, 0, 1, 16'h0000), 32'h1234_5678, "R8");
        peek(0, 32'h0, "R8");
        run(1, rty('h01, 13, 1, 1, 0), 0, "R9");
        run(1, ity('h3F, 13, 1, 16'h1111), 0, "R9");
        run(1, ity('h2B | 'h10, 13, 1, 16'h0004), 0, "R9");
        peek(13, 32'h0, "R9");
        run(0, ity('h08, 13, 1, 16'h0001), 0, "R10");
        run(0, ity('h23, 13, 1, 16'h0001), 32'hFFFF_FFFF, "R10");
        peek(13, 32'h0, "R10");

        for (int n = 0; n < 400; n++) begin
            logic [31:0] ins;
            int sel;
            sel = int'($urandom % 16);
            case (sel)
                0:  ins = rty('h20, $urandom%32, $urandom%32, $urandom%32, 0);
                1:  ins = rty('h22, $urandom%32, $urandom%32, $urandom%32, 0);
                2:  ins = rty('h24, $urandom%32, $urandom%32, $urandom%32, 0);
                3:  ins = rty('h25, $urandom%32, $urandom%32, $urandom%32, 0);
                4:  ins = rty('h26, $urandom%32, $urandom%32, $urandom%32, 0);
                5:  ins = rty('h27, $urandom%32, $urandom%32, $urandom%32, 0);
                6:  ins = rty('h00, $urandom%32, 0, $urandom%32, $urandom%32);
                7:  ins = rty('h02, $urandom%32, 0, $urandom%32, $urandom%32);
                8:  ins = rty('h03, $urandom%32, 0, $urandom%32, $urandom%32);
                9:  ins = ity('h08, $urandom%32, $urandom%32, 16'($urandom));
                10: ins = ity('h0C, $urandom%32, $urandom%32, 16'($urandom));
                11: ins = ity('h0D, $urandom%32, $urandom%32, 16'($urandom));
                12: ins = ity('h0E, $urandom%32, $urandom%32, 16'($urandom));
                13: ins = ity('h23, $urandom%32, $urandom%32, 16'($urandom));
                14: ins = ity('h2B, $urandom%32, $urandom%32, 16'($urandom));
                default: ins = $urandom;
            endcase
            run(($urandom % 8) != 0, ins, $urandom, "R1..R10 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule